// File: doc/BRIEF.md
# Lossless Receive Flow Control Monitor

This block watches a set of receive descriptor rings and asks for link-layer flow control when any ring in use is running out of descriptors that the receiver can still fill. For every ring it takes the ring length, a producer index, a consumer index, a free-descriptor threshold and an in-use flag. It works out how many free descriptors each ring holds. If any ring in use holds fewer than its threshold, it raises one combined shortage condition.

The way this condition is signalled depends on the link type, chosen by a mode input. On a full-duplex Ethernet link, the block sends a one-cycle pause request to the transmit side. That request acts the same as a software pause command. On a FIFO packet interface, the block drives a level flow-control output for as long as the shortage lasts. A global enable turns the monitor on. Software should change that enable only after reset or after the receiver has stopped gracefully. Building the pause frame and handling descriptors are done elsewhere.

Top module: `rx_lossless_fc_monitor`

## Requirements
- R1: After reset, `pauseReq` and `rxFlowCtl` are both 0.
- R2: While `fcEnable` is 0, neither `pauseReq` nor `rxFlowCtl` is asserted, whatever the ring inputs are.
- R3: The free count of ring i is `ringLen[i] - occ`, where `occ = prodIdx[i] - consIdx[i]` if `prodIdx[i] >= consIdx[i]`, and `prodIdx[i] + ringLen[i] - consIdx[i]` otherwise. So equal indices give a free count equal to the length.
- R4: A ring is short only when its free count is strictly less than `freeThresh[i]`. A free count equal to the threshold is not short.
- R5: A ring whose `ringActive[i]` bit is 0 never causes flow control, even if its free count is below its threshold.
- R6: The combined shortage is the OR over all active rings, so a shortage in any one active ring, including the highest-numbered ring, triggers flow control.
- R7: With `fifoMode` = 0 (full-duplex Ethernet), a rise of the combined shortage gives `pauseReq` = 1 for exactly one cycle, and `rxFlowCtl` stays 0.
- R8: With `fifoMode` = 0, no further pause request is issued while the shortage persists. A new pulse comes only after the shortage clears and then returns.
- R9: With `fifoMode` = 1 (FIFO packet interface), `rxFlowCtl` equals the combined shortage as a level, and `pauseReq` stays 0.
- R10: Both outputs respond to the inputs held before the second rising clock edge after they change. There is one register stage for the shortage and one for the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcEnable | input | 1 | Global monitor enable |
| fifoMode | input | 1 | 0 = full-duplex Ethernet (pause pulse), 1 = FIFO packet interface (level) |
| ringActive | input | NUM_RINGS | Per-ring in-use flag |
| ringLen | input | NUM_RINGS x (IDX_W+1) | Per-ring length, 1 to 2^IDX_W |
| prodIdx | input | NUM_RINGS x IDX_W | Per-ring producer index, below the length |
| consIdx | input | NUM_RINGS x IDX_W | Per-ring consumer index, below the length |
| freeThresh | input | NUM_RINGS x (IDX_W+1) | Per-ring free-descriptor threshold |
| pauseReq | output | 1 | One-cycle pause-frame request |
| rxFlowCtl | output | 1 | Level flow-control signal for a FIFO interface |

## Verification
The assertions assume three things about the inputs: every ring length is at least one, both indices lie below that length, and the enable and mode inputs are driven to known values from reset onward. The random stimulus picks each length in 1..2^IDX_W and draws both indices modulo that length. Directed cases separately cover wraparound, equal indices, and a free count exactly equal to the threshold. Mode changes are made only while all rings are inactive, so that every pulse the bench observes comes from a shortage edge and not from a mode switch.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  // strobes from the control half into the datapath half
  typedef struct packed {
    logic evalEn;    // sample the combined shortage this cycle
    logic clearAll;  // force the registered shortage low
  } fcStrobe_t;
endpackage

// File: rtl/rxfc_ring_free.sv
module rxfc_ring_free #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W:0]   ringLen,
  input  logic [IDX_W-1:0] prodIdx,
  input  logic [IDX_W-1:0] consIdx,
  input  logic [IDX_W:0]   freeThresh,
  output logic             isShort
);
  localparam int LEN_W = IDX_W + 1;

  logic [LEN_W-1:0] prodExt, consExt, occ, freeCnt;

  always_comb begin
    prodExt = {1'b0, prodIdx};
    consExt = {1'b0, consIdx};
    // distance from consumer to producer, wrapping at the ring length
    if (prodExt >= consExt) occ = prodExt - consExt;
    else                    occ = prodExt + ringLen - consExt;
    freeCnt = ringLen - occ;
    isShort = (freeCnt < freeThresh);
  end
endmodule

// File: rtl/rxfc_datapath.sv
module rxfc_datapath
  import rxfc_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int IDX_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  fcStrobe_t                        strobe,
  input  logic [NUM_RINGS-1:0]             ringActive,
  input  logic [NUM_RINGS-1:0][IDX_W:0]    ringLen,
  input  logic [NUM_RINGS-1:0][IDX_W-1:0]  prodIdx,
  input  logic [NUM_RINGS-1:0][IDX_W-1:0]  consIdx,
  input  logic [NUM_RINGS-1:0][IDX_W:0]    freeThresh,
  output logic                             anyShort
);
  logic [NUM_RINGS-1:0] ringShort;
  logic [NUM_RINGS-1:0] activeShort;

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    rxfc_ring_free #(.IDX_W(IDX_W)) u_free (
      .ringLen   (ringLen[g]),
      .prodIdx   (prodIdx[g]),
      .consIdx   (consIdx[g]),
      .freeThresh(freeThresh[g]),
      .isShort   (ringShort[g])
    );
    assign activeShort[g] = ringShort[g] & ringActive[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               anyShort <= 1'b0;
    else if (strobe.clearAll) anyShort <= 1'b0;
    else if (strobe.evalEn)   anyShort <= |activeShort;
  end
endmodule

// File: rtl/rxfc_control.sv
module rxfc_control
  import rxfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fcEnable,
  input  logic      fifoMode,
  input  logic      anyShort,
  output fcStrobe_t strobe,
  output logic      pauseReq,
  output logic      rxFlowCtl
);
  logic prevShort;

  always_comb begin
    strobe.evalEn   = fcEnable;
    strobe.clearAll = !fcEnable;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevShort <= 1'b0;
      pauseReq  <= 1'b0;
      rxFlowCtl <= 1'b0;
    end else begin
      prevShort <= anyShort;
      pauseReq  <= fcEnable && !fifoMode && anyShort && !prevShort;
      rxFlowCtl <= fcEnable && fifoMode && anyShort;
    end
  end
endmodule

// File: rtl/rx_lossless_fc_monitor.sv
module rx_lossless_fc_monitor
  import rxfc_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int IDX_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fcEnable,
  input  logic                             fifoMode,
  input  logic [NUM_RINGS-1:0]             ringActive,
  input  logic [NUM_RINGS-1:0][IDX_W:0]    ringLen,
  input  logic [NUM_RINGS-1:0][IDX_W-1:0]  prodIdx,
  input  logic [NUM_RINGS-1:0][IDX_W-1:0]  consIdx,
  input  logic [NUM_RINGS-1:0][IDX_W:0]    freeThresh,
  output logic                             pauseReq,
  output logic                             rxFlowCtl
);
  fcStrobe_t strobe;
  logic      anyShort;

  rxfc_datapath #(.NUM_RINGS(NUM_RINGS), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .ringActive(ringActive),
    .ringLen   (ringLen),
    .prodIdx   (prodIdx),
    .consIdx   (consIdx),
    .freeThresh(freeThresh),
    .anyShort  (anyShort)
  );

  rxfc_control u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fcEnable (fcEnable),
    .fifoMode (fifoMode),
    .anyShort (anyShort),
    .strobe   (strobe),
    .pauseReq (pauseReq),
    .rxFlowCtl(rxFlowCtl)
  );
endmodule

// File: rtl/rxfc_monitor_checker.sv
module rxfc_monitor_checker #(
  parameter int NUM_RINGS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fcEnable,
  input logic                 fifoMode,
  input logic [NUM_RINGS-1:0] ringActive,
  input logic                 pauseReq,
  input logic                 rxFlowCtl
);
  // R7: the pause request never lasts more than one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pauseReq |=> !pauseReq);

  // R2: a disabled monitor drives no flow control on the next cycle
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fcEnable |=> (!pauseReq && !rxFlowCtl));

  // R9: the level output appears only in FIFO mode
  a_r9_level_only_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    rxFlowCtl |-> $past(fifoMode));

  // R7: the pulse appears only in Ethernet mode
  a_r7_pulse_only_eth: assert property (@(posedge clk) disable iff (!rst_n)
    pauseReq |-> !$past(fifoMode));

  // R5: with no ring active two cycles back, nothing is signalled
  a_r5_inactive_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ringActive, 2) == '0) |-> (!pauseReq && !rxFlowCtl));

  // R1: outputs are low while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_low: assert (!pauseReq && !rxFlowCtl);
    end
  end
endmodule

bind rx_lossless_fc_monitor rxfc_monitor_checker #(.NUM_RINGS(NUM_RINGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fcEnable  (fcEnable),
  .fifoMode  (fifoMode),
  .ringActive(ringActive),
  .pauseReq  (pauseReq),
  .rxFlowCtl (rxFlowCtl)
);

// File: tb/rx_lossless_fc_monitor_bench.sv
module rx_lossless_fc_monitor_bench;
  localparam int NR = 4;
  localparam int IW = 6;
  localparam int MAXLEN = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcEnable = 1'b0;
  logic fifoMode = 1'b0;
  logic [NR-1:0] act = '0;
  logic [NR-1:0][IW:0] lenA = '0;
  logic [NR-1:0][IW-1:0] prodA = '0;
  logic [NR-1:0][IW-1:0] consA = '0;
  logic [NR-1:0][IW:0] thrA = '0;
  logic pauseReq, rxFlowCtl;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rx_lossless_fc_monitor #(.NUM_RINGS(NR), .IDX_W(IW)) u_rx_lossless_fc_monitor (
    .clk(clk), .rst_n(rst_n), .fcEnable(fcEnable), .fifoMode(fifoMode),
    .ringActive(act), .ringLen(lenA), .prodIdx(prodA), .consIdx(consA),
    .freeThresh(thrA), .pauseReq(pauseReq), .rxFlowCtl(rxFlowCtl)
  );

  function automatic int expFree(int len, int p, int c);
    int occ;
    occ = (p >= c) ? p - c : p + len - c;
    return len - occ;
  endfunction

  function automatic bit expShort();
    bit s = 1'b0;
    for (int i = 0; i < NR; i++)
      if (act[i] && expFree(int'(lenA[i]), int'(prodA[i]), int'(consA[i])) < int'(thrA[i]))
        s = 1'b1;
    return s;
  endfunction

  task automatic check(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setRing(int i, int len, int p, int c, int t, bit a);
    lenA[i] = (IW+1)'(len); prodA[i] = IW'(p); consA[i] = IW'(c);
    thrA[i] = (IW+1)'(t); act[i] = a;
  endtask

  task automatic allCalm();
    for (int i = 0; i < NR; i++) setRing(i, 16, 0, 0, 0, 1'b0);
  endtask

  task automatic randomRings();
    for (int i = 0; i < NR; i++) begin
      int len = 1 + int'($urandom % MAXLEN);
      setRing(i, len, int'($urandom % len), int'($urandom % len),
              int'($urandom % (MAXLEN + 2)), 1'($urandom));
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd2024));
    allCalm();
    step(3);
    // R1 reset state
    check("R1 pauseReq", pauseReq, 0);
    check("R1 rxFlowCtl", rxFlowCtl, 0);
    rst_n = 1'b1;
    step(2);

    // R2: disabled with every ring short, both modes
    for (int i = 0; i < NR; i++) setRing(i, 8, 3, 3, 9, 1'b1);
    fifoMode = 1'b1; step(3);
    check("R2 fifo disabled", rxFlowCtl, 0);
    allCalm(); fifoMode = 1'b0; step(2);
    for (int i = 0; i < NR; i++) setRing(i, 8, 3, 3, 9, 1'b1);
    step(2);
    check("R2 eth disabled", pauseReq, 0);
    allCalm(); step(2);

    fcEnable = 1'b1; fifoMode = 1'b1; step(2);
    // R3/R4: wraparound len16 p2 c14 -> free 12
    setRing(0, 16, 2, 14, 13, 1'b1); step(2);
    check("R3 wrap free12 thr13", rxFlowCtl, 1);
    setRing(0, 16, 2, 14, 12, 1'b1); step(2);
    check("R4 free equals thr", rxFlowCtl, 0);
    setRing(0, 16, 5, 5, 16, 1'b1); step(2);
    check("R3 equal idx free=len", rxFlowCtl, 0);
    setRing(0, 16, 5, 5, 17, 1'b1); step(2);
    check("R3 equal idx thr len+1", rxFlowCtl, 1);
    // R10 latency: one edge after a change the old value is still out
    setRing(0, 16, 5, 5, 0, 1'b1); step(1);
    check("R10 latency hold", rxFlowCtl, 1);
    step(1);
    check("R10 latency update", rxFlowCtl, 0);
    // R5 inactive short ring ignored
    allCalm(); setRing(1, 4, 3, 0, 4, 1'b0); step(2);
    check("R5 inactive ignored", rxFlowCtl, 0);
    check("R9 no pulse in fifo", pauseReq, 0);
    // R6 highest ring alone short
    setRing(NR-1, 4, 3, 0, 2, 1'b1); step(2);
    check("R6 last ring short", rxFlowCtl, 1);
    check("R9 pulse stays low", pauseReq, 0);
    // R2: dropping enable mid-shortage
    fcEnable = 1'b0; step(2);
    check("R2 enable dropped", rxFlowCtl, 0);
    allCalm(); step(2);

    // R7/R8 Ethernet pulse behaviour
    fcEnable = 1'b1; fifoMode = 1'b0; step(2);
    setRing(2, 32, 10, 0, 23, 1'b1); step(2);
    check("R7 pulse on rise", pauseReq, 1);
    check("R7 no level in eth", rxFlowCtl, 0);
    step(1);
    check("R7 pulse one cycle", pauseReq, 0);
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin step(1); seen += int'(pauseReq); end
      check("R8 no reissue while held", seen, 0);
    end
    setRing(2, 32, 10, 0, 22, 1'b1); step(3);
    check("R8 cleared", pauseReq, 0);
    setRing(2, 32, 10, 0, 23, 1'b1); step(2);
    check("R8 reissue after return", pauseReq, 1);
    allCalm(); step(3);

    // random, FIFO mode: R3 R4 R5 R6 R9
    fifoMode = 1'b1; step(2);
    for (int n = 0; n < 300; n++) begin
      bit e;
      randomRings(); e = expShort(); step(2);
      check("R9 random level", rxFlowCtl, int'(e));
      check("R9 random no pulse", pauseReq, 0);
    end
    allCalm(); step(3);

    // random, Ethernet mode: R7 R8
    fifoMode = 1'b0; step(2);
    for (int n = 0; n < 300; n++) begin
      bit e;
      allCalm(); step(3);
      randomRings(); e = expShort(); step(2);
      check("R7 random pulse", pauseReq, int'(e));
      step(1);
      check("R7 random pulse ends", pauseReq, 0);
    end
    finish();
  end
endmodule